// File: doc/BRIEF.md
# Calendar Time-Keeping Update Engine

This block holds wall-clock time and date in a small indexed register file and steps it forward once per second when a one-hertz tick arrives. Each step is announced by an update-in-progress flag that goes high a fixed number of clock cycles before any time register moves. The flag stays high for a further settling window after the registers move. Software therefore polls the flag and reads only while it is low.

Values are kept either as packed BCD digits or as plain binary. Hours run in either 24-hour form or 12-hour form, where the hour MSB marks afternoon. A control bit freezes stepping so that the host can load a new time. After each step, the time is compared against three alarm fields, and any alarm field with both top bits set matches every value. The host picks a register by writing its number to an index port, then reads or writes it through a shared data path.

Top module: `rtc_core`

## Requirements
- R1: After reset the index is 0, seconds, minutes, hours, year and all alarm fields read 0, day of week, day of month and month read 1, index 11 reads 0x02, and uip_o is low.
- R2: Writing with idx_we_i loads wdata_i[3:0] as the index. rdata_o then shows the selected register, and dat_we_i writes it. Time indexes are 0 sec, 1 sec alarm, 2 min, 3 min alarm, 4 hour, 5 hour alarm, 6 day of week, 7 day of month, 8 month, 9 year. Indexes 12 to 15 read 0, and writes to them are dropped.
- R3: With the freeze bit clear, a tick raises uip_o and bit 7 of index 10 from the next cycle. The time registers change LEAD_CYC cycles after the flag rises and stay unchanged otherwise, unless the host writes them.
- R4: uip_o stays high UPD_CYC cycles after the registers change. upd_done_o pulses for one cycle in the last high cycle, and the flag clears the cycle after.
- R5: Index 11 bit 7 is the freeze bit. While it is 1, ticks are ignored, and setting it during a pending step cancels that step with no register change and no pulse.
- R6: With index 11 bit 2 clear, values are BCD. Each digit pair carries decimally, seconds carry into minutes, minutes into hours, and hours into the date, and year 99 steps to 00.
- R7: With index 11 bit 2 set, all values are plain binary and step with the same carries.
- R8: Day of month wraps to 1 after 30 in months 4, 6, 9 and 11, and after 31 in the other months. In month 2 it wraps after 28, or after 29 when the year is a multiple of 4. Month 12 wraps to 1 and carries into the year.
- R9: Day of week steps 1 to 7 and wraps from 7 to 1 when the date advances.
- R10: With index 11 bit 1 clear, hours run 12, 1, ..., 11 with bit 7 meaning PM. 11 to 12 toggles PM, and the date advances only when 11 PM becomes 12 AM.
- R11: alarm_o pulses together with upd_done_o when the hour, minute and second fields each equal their alarm field. An alarm field whose bits 7:6 are both 1 matches any value.
- R12: Index 10 reads the update flag in bit 7 and 0 elsewhere, and host writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| idx_we_i | input | 1 | Load register index from wdata_i |
| dat_we_i | input | 1 | Write wdata_i into selected register |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Selected register contents |
| uip_o | output | 1 | Update in progress |
| upd_done_o | output | 1 | One-cycle pulse when a step completes |
| alarm_o | output | 1 | One-cycle pulse on alarm match |

## Verification
The checks assume that the tick is a single-cycle pulse and that the host leaves the time registers alone while the update flag is high. They also assume that stored values are legal for the active encoding and hour form. The stimulus loads every time with the freeze bit set, clears it, and only then issues a tick. It waits out the whole flag window before any further host access. The one deliberate access inside the window is the freeze-bit write that cancels a step.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_HOLD} seq_st_e;

  localparam int unsigned NUM_TREG = 10;
  localparam int unsigned IX_SEC   = 0;
  localparam int unsigned IX_SECA  = 1;
  localparam int unsigned IX_MIN   = 2;
  localparam int unsigned IX_MINA  = 3;
  localparam int unsigned IX_HR    = 4;
  localparam int unsigned IX_HRA   = 5;
  localparam int unsigned IX_DOW   = 6;
  localparam int unsigned IX_DOM   = 7;
  localparam int unsigned IX_MON   = 8;
  localparam int unsigned IX_YR    = 9;
  localparam int unsigned IX_STAT  = 10;
  localparam int unsigned IX_CTRL  = 11;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hr;
    logic [7:0] dow;
    logic [7:0] dom;
    logic [7:0] mon;
    logic [7:0] yr;
  } tod_t;

  function automatic logic [7:0] from_fmt(input logic [7:0] v, input logic bin);
    logic [7:0] t;
    t = ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
    return bin ? v : t;
  endfunction

  function automatic logic [7:0] to_fmt(input logic [7:0] v, input logic bin);
    logic [7:0] q, r;
    q = v / 8'd10;
    r = v - (q * 8'd10);
    return bin ? v : {q[3:0], r[3:0]};
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
    logic [7:0] n;
    case (m)
      8'd2:                      n = (y[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   n = 8'd30;
      default:                   n = 8'd31;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/rtc_seq.sv
module rtc_seq #(
  parameter int unsigned LEAD_CYC = 4,
  parameter int unsigned UPD_CYC  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hold_i,
  output logic uip_o,
  output logic adv_o,
  output logic done_o
);
  import rtc_pkg::*;

  localparam int unsigned MAXC  = (LEAD_CYC > UPD_CYC) ? LEAD_CYC : UPD_CYC;
  localparam int unsigned CNT_W = $clog2(MAXC + 1);

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lead_end, hold_end;

  assign lead_end = (st_q == ST_LEAD) && (cnt_q == CNT_W'(LEAD_CYC - 1));
  assign hold_end = (st_q == ST_HOLD) && (cnt_q == CNT_W'(UPD_CYC - 1));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q + CNT_W'(1);
    unique case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (tick_i) st_d = ST_LEAD;
      end
      ST_LEAD: if (lead_end) begin st_d = ST_HOLD; cnt_d = '0; end
      ST_HOLD: if (hold_end) begin st_d = ST_IDLE; cnt_d = '0; end
      default: begin st_d = ST_IDLE; cnt_d = '0; end
    endcase
    // freeze wins over every state
    if (hold_i) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign uip_o  = (st_q != ST_IDLE);
  assign adv_o  = lead_end && !hold_i;
  assign done_o = hold_end && !hold_i;
endmodule

// File: rtl/rtc_advance.sv
module rtc_advance #(
  parameter int unsigned YEAR_WRAP = 100
) (
  input  rtc_pkg::tod_t cur_i,
  input  logic          bin_i,
  input  logic          h24_i,
  output rtc_pkg::tod_t nxt_o
);
  import rtc_pkg::*;

  logic [7:0] s, m, h, dw, d, mo, y, dim;
  logic [7:0] ns, nm, nh, ndw, nd, nmo, ny, hb;
  logic       pm, npm, c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    s   = from_fmt(cur_i.sec, bin_i);
    m   = from_fmt(cur_i.min, bin_i);
    h   = h24_i ? from_fmt(cur_i.hr, bin_i) : from_fmt({1'b0, cur_i.hr[6:0]}, bin_i);
    pm  = ~h24_i & cur_i.hr[7];
    dw  = from_fmt(cur_i.dow, bin_i);
    d   = from_fmt(cur_i.dom, bin_i);
    mo  = from_fmt(cur_i.mon, bin_i);
    y   = from_fmt(cur_i.yr, bin_i);
    dim = month_len(mo, y);

    c_min = 1'b0; c_hr = 1'b0; c_day = 1'b0; c_mon = 1'b0; c_yr = 1'b0;
    npm = pm;
    nm = m; nh = h; ndw = dw; nd = d; nmo = mo; ny = y;

    if (s >= 8'd59) begin ns = 8'd0; c_min = 1'b1; end
    else ns = s + 8'd1;

    if (c_min) begin
      if (m >= 8'd59) begin nm = 8'd0; c_hr = 1'b1; end
      else nm = m + 8'd1;
    end

    if (c_hr) begin
      if (h24_i) begin
        if (h >= 8'd23) begin nh = 8'd0; c_day = 1'b1; end
        else nh = h + 8'd1;
      end else if (h == 8'd11) begin
        nh    = 8'd12;
        npm   = ~pm;
        c_day = pm;
      end else if (h >= 8'd12) begin
        nh = 8'd1;
      end else begin
        nh = h + 8'd1;
      end
    end

    if (c_day) begin
      ndw = (dw >= 8'd7) ? 8'd1 : dw + 8'd1;
      if (d >= dim) begin nd = 8'd1; c_mon = 1'b1; end
      else nd = d + 8'd1;
    end

    if (c_mon) begin
      if (mo >= 8'd12) begin nmo = 8'd1; c_yr = 1'b1; end
      else nmo = mo + 8'd1;
    end

    if (c_yr) ny = (y >= 8'(YEAR_WRAP - 1)) ? 8'd0 : y + 8'd1;

    hb        = to_fmt(nh, bin_i);
    nxt_o.sec = to_fmt(ns, bin_i);
    nxt_o.min = to_fmt(nm, bin_i);
    nxt_o.hr  = h24_i ? hb : {npm, hb[6:0]};
    nxt_o.dow = to_fmt(ndw, bin_i);
    nxt_o.dom = to_fmt(nd, bin_i);
    nxt_o.mon = to_fmt(nmo, bin_i);
    nxt_o.yr  = to_fmt(ny, bin_i);
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int unsigned NFIELD = 3,
  parameter int unsigned FW     = 8
) (
  input  logic [NFIELD-1:0][FW-1:0] cur_i,
  input  logic [NFIELD-1:0][FW-1:0] alm_i,
  output logic                      hit_o
);
  logic [NFIELD-1:0] fhit;

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    assign fhit[g] = (&alm_i[g][FW-1:FW-2]) || (alm_i[g] == cur_i[g]);
  end

  assign hit_o = &fhit;
endmodule

// File: rtl/rtc_core.sv
module rtc_core #(
  parameter int unsigned LEAD_CYC  = 4,
  parameter int unsigned UPD_CYC   = 8,
  parameter int unsigned YEAR_WRAP = 100,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned DW        = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          idx_we_i,
  input  logic          dat_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          uip_o,
  output logic          upd_done_o,
  output logic          alarm_o
);
  import rtc_pkg::*;

  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    treg [NUM_TREG];
  logic             set_q, bin_q, h24_q;
  logic             adv, done, hit, sec_wr;
  tod_t             cur, nxt;

  assign cur.sec = treg[IX_SEC];
  assign cur.min = treg[IX_MIN];
  assign cur.hr  = treg[IX_HR];
  assign cur.dow = treg[IX_DOW];
  assign cur.dom = treg[IX_DOM];
  assign cur.mon = treg[IX_MON];
  assign cur.yr  = treg[IX_YR];

  assign sec_wr = dat_we_i && (idx_q == IDX_W'(IX_SEC));

  rtc_seq #(.LEAD_CYC(LEAD_CYC), .UPD_CYC(UPD_CYC)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .hold_i (set_q),
    .uip_o  (uip_o),
    .adv_o  (adv),
    .done_o (done)
  );

  rtc_advance #(.YEAR_WRAP(YEAR_WRAP)) u_adv (
    .cur_i (cur),
    .bin_i (bin_q),
    .h24_i (h24_q),
    .nxt_o (nxt)
  );

  rtc_alarm_cmp #(.NFIELD(3), .FW(DW)) u_alm (
    .cur_i ({treg[IX_HR], treg[IX_MIN], treg[IX_SEC]}),
    .alm_i ({treg[IX_HRA], treg[IX_MINA], treg[IX_SECA]}),
    .hit_o (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      for (int i = 0; i < NUM_TREG; i++) treg[i] <= '0;
      treg[IX_DOW] <= DW'(1);
      treg[IX_DOM] <= DW'(1);
      treg[IX_MON] <= DW'(1);
      set_q <= 1'b0;
      bin_q <= 1'b0;
      h24_q <= 1'b1;
    end else begin
      if (idx_we_i) idx_q <= wdata_i[IDX_W-1:0];
      if (dat_we_i) begin
        for (int i = 0; i < NUM_TREG; i++)
          if (idx_q == IDX_W'(i)) treg[i] <= wdata_i;
        if (idx_q == IDX_W'(IX_CTRL)) begin
          set_q <= wdata_i[7];
          bin_q <= wdata_i[2];
          h24_q <= wdata_i[1];
        end
      end
      // step overrides a same-cycle host write
      if (adv) begin
        treg[IX_SEC] <= nxt.sec;
        treg[IX_MIN] <= nxt.min;
        treg[IX_HR]  <= nxt.hr;
        treg[IX_DOW] <= nxt.dow;
        treg[IX_DOM] <= nxt.dom;
        treg[IX_MON] <= nxt.mon;
        treg[IX_YR]  <= nxt.yr;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_TREG; i++)
      if (idx_q == IDX_W'(i)) rdata_o = treg[i];
    if (idx_q == IDX_W'(IX_STAT)) rdata_o = {uip_o, {(DW-1){1'b0}}};
    if (idx_q == IDX_W'(IX_CTRL)) rdata_o = {set_q, 4'b0000, bin_q, h24_q, 1'b0};
  end

  assign upd_done_o = done;
  assign alarm_o    = done && hit;
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       uip_i,
  input logic       adv_i,
  input logic       done_i,
  input logic       alarm_i,
  input logic       set_i,
  input logic       sec_wr_i,
  input logic [7:0] sec_i
);
  p_tick_starts_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !set_i && !uip_i) |=> uip_i);

  p_adv_in_uip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> uip_i);

  p_sec_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !sec_wr_i) |=> $stable(sec_i));

  p_done_in_uip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> uip_i);

  p_uip_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !uip_i);

  p_done_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  p_freeze_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> !uip_i);

  p_alarm_with_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_i |-> done_i);
endmodule

bind rtc_core rtc_core_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .uip_i    (uip_o),
  .adv_i    (adv),
  .done_i   (upd_done_o),
  .alarm_i  (alarm_o),
  .set_i    (set_q),
  .sec_wr_i (sec_wr),
  .sec_i    (treg[0])
);

// File: tb/rtc_core_tb.sv
module rtc_core_tb;
  localparam int LEAD = 4;
  localparam int UPD  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, idx_we = 1'b0, dat_we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       uip, done, alarm;

  int total = 0;
  int bad   = 0;
  bit exp_q[$];

  always #4 clk = ~clk;

  rtc_core #(.LEAD_CYC(LEAD), .UPD_CYC(UPD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .idx_we_i(idx_we),
    .dat_we_i(dat_we), .wdata_i(wdata), .rdata_o(rdata), .uip_o(uip),
    .upd_done_o(done), .alarm_o(alarm)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr_idx(input logic [7:0] i);
    @(negedge clk); idx_we = 1'b1; wdata = i;
    @(negedge clk); idx_we = 1'b0;
  endtask

  task automatic wr_dat(input logic [7:0] v);
    @(negedge clk); dat_we = 1'b1; wdata = v;
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic put(input logic [7:0] i, input logic [7:0] v);
    wr_idx(i); wr_dat(v);
  endtask

  task automatic rd(input logic [7:0] i, output logic [7:0] v);
    wr_idx(i); v = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] i, input logic [7:0] exp);
    logic [7:0] v;
    rd(i, v); chk(tag, v, exp);
  endtask

  task automatic load(input logic [7:0] mode, input logic [7:0] s, input logic [7:0] m,
                      input logic [7:0] h, input logic [7:0] dw, input logic [7:0] d,
                      input logic [7:0] mo, input logic [7:0] y);
    put(11, mode | 8'h80);
    put(0, s); put(2, m); put(4, h); put(6, dw); put(7, d); put(8, mo); put(9, y);
    put(11, mode);
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic step(input bit exp_alarm);
    exp_q.push_back(exp_alarm);
    pulse_tick();
    repeat (LEAD + UPD + 3) @(negedge clk);
  endtask

  task automatic tchk(input string tag, input logic [7:0] s, input logic [7:0] m,
                      input logic [7:0] h, input logic [7:0] dw, input logic [7:0] d,
                      input logic [7:0] mo, input logic [7:0] y);
    rd_chk({tag, " sec"}, 0, s);
    rd_chk({tag, " min"}, 2, m);
    rd_chk({tag, " hr"},  4, h);
    rd_chk({tag, " dow"}, 6, dw);
    rd_chk({tag, " dom"}, 7, d);
    rd_chk({tag, " mon"}, 8, mo);
    rd_chk({tag, " yr"},  9, y);
  endtask

  // monitor: scoreboard of alarm outcome per completed step (R4, R11)
  always @(negedge clk) begin
    if (rst_n && done) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R4/R5 unexpected done got=1 exp=0");
      end else begin
        bit e;
        e = exp_q.pop_front();
        if (alarm !== e) begin
          bad++;
          $display("FAIL R11 alarm got=%b exp=%b", alarm, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 uip", {7'd0, uip}, 8'd0);
    chk("R1 index0", rdata, 8'h00);
    rd_chk("R1 dow", 6, 8'h01);
    rd_chk("R1 mon", 8, 8'h01);
    rd_chk("R1 ctrl", 11, 8'h02);
    rd_chk("R1 hr alarm", 5, 8'h00);

    // R2 index/data access, unused index
    put(3, 8'h5A);
    rd_chk("R2 min alarm", 3, 8'h5A);
    put(13, 8'hFF);
    rd_chk("R2 unused", 13, 8'h00);
    rd_chk("R2 min alarm kept", 3, 8'h5A);
    // R12 status write ignored
    put(10, 8'hFF);
    rd_chk("R12 status", 10, 8'h00);

    // park alarms on a value that never matches
    put(1, 8'h77); put(3, 8'h00); put(5, 8'h00);

    // R3/R4 timing, R6 BCD digit carry 09 -> 10
    load(8'h02, 8'h09, 8'h15, 8'h09, 8'h03, 8'h05, 8'h05, 8'h23);
    wr_idx(0);
    exp_q.push_back(1'b0);
    pulse_tick();
    chk("R3 uip rise", {7'd0, uip}, 8'd1);
    repeat (LEAD - 1) @(negedge clk);
    chk("R3 sec before change", rdata, 8'h09);
    chk("R3 uip lead", {7'd0, uip}, 8'd1);
    @(negedge clk);
    chk("R3 sec changed", rdata, 8'h10);
    repeat (UPD - 1) @(negedge clk);
    chk("R4 done last cycle", {7'd0, done}, 8'd1);
    chk("R4 uip still high", {7'd0, uip}, 8'd1);
    @(negedge clk);
    chk("R4 uip cleared", {7'd0, uip}, 8'd0);
    chk("R4 done single", {7'd0, done}, 8'd0);
    repeat (3) @(negedge clk);
    tchk("R6 bcd sec", 8'h10, 8'h15, 8'h09, 8'h03, 8'h05, 8'h05, 8'h23);

    // R6 R9 BCD full rollover, year 99 -> 00, dow 7 -> 1
    load(8'h02, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    step(1'b0);
    tchk("R6 R9 rollover", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);

    // R7 R8 binary, leap February 28 -> 29
    load(8'h06, 8'd59, 8'd59, 8'd23, 8'd3, 8'd28, 8'd2, 8'd24);
    step(1'b0);
    tchk("R7 R8 bin leap", 8'd0, 8'd0, 8'd0, 8'd4, 8'd29, 8'd2, 8'd24);

    // R8 non-leap February in BCD
    load(8'h02, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
    step(1'b0);
    tchk("R8 feb", 8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h23);

    // R8 30-day month
    load(8'h02, 8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h23);
    step(1'b0);
    tchk("R8 apr", 8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h05, 8'h23);

    // R10 12-hour BCD: 11 AM -> 12 PM, no date change
    load(8'h00, 8'h59, 8'h59, 8'h11, 8'h01, 8'h10, 8'h06, 8'h23);
    step(1'b0);
    tchk("R10 noon", 8'h00, 8'h00, 8'h92, 8'h01, 8'h10, 8'h06, 8'h23);
    // R10 11 PM -> 12 AM, date advances
    load(8'h00, 8'h59, 8'h59, 8'h91, 8'h01, 8'h10, 8'h06, 8'h23);
    step(1'b0);
    tchk("R10 midnight", 8'h00, 8'h00, 8'h12, 8'h02, 8'h11, 8'h06, 8'h23);
    // R10 12 PM -> 1 PM
    load(8'h00, 8'h59, 8'h59, 8'h92, 8'h01, 8'h10, 8'h06, 8'h23);
    step(1'b0);
    rd_chk("R10 one pm", 4, 8'h81);

    // R5 freeze: tick ignored
    load(8'h02, 8'h20, 8'h20, 8'h10, 8'h01, 8'h10, 8'h06, 8'h23);
    put(11, 8'h82);
    pulse_tick();
    chk("R5 no uip", {7'd0, uip}, 8'd0);
    repeat (LEAD + UPD + 2) @(negedge clk);
    rd_chk("R5 frozen sec", 0, 8'h20);
    // R5 cancel a pending step
    put(11, 8'h02);
    wr_idx(11);
    pulse_tick();
    wr_dat(8'h82);
    repeat (LEAD + UPD + 2) @(negedge clk);
    chk("R5 cancel uip", {7'd0, uip}, 8'd0);
    rd_chk("R5 cancel sec", 0, 8'h20);
    put(11, 8'h02);

    // R11 exact match
    load(8'h02, 8'h30, 8'h20, 8'h10, 8'h01, 8'h10, 8'h06, 8'h23);
    put(1, 8'h31); put(3, 8'h20); put(5, 8'h10);
    step(1'b1);
    // R11 don't-care on seconds and minutes
    put(1, 8'hC0); put(3, 8'hFF);
    step(1'b1);
    // R11 hour mismatch
    put(5, 8'h11);
    step(1'b0);
    rd_chk("R11 sec after", 0, 8'h33);

    repeat (4) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R4 missing done got=%0d exp=0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule